// File: doc/BRIEF.md
# Triggered Waveform Update Sequencer

This block is the timing engine of a multi-channel D/A waveform generator. After software arms it with a set of counter values, a start trigger launches one run. The run can wait for an optional start delay. It then emits a DAC write strobe once per update interval. It groups those strobes into waveforms of a programmed length and repeats the waveform a programmed number of times, or without end. An optional gap delay can separate consecutive waveforms. A stop trigger aborts the run at once.

Each strobe comes with a pattern-buffer read request and the index of the sample being written. That index keeps advancing across waveform boundaries and wraps at the stored pattern length. When a waveform is shorter than the pattern, successive waveforms therefore step through the pattern piece by piece. Invalid counter settings are caught at arm time and raise an error flag instead of arming the sequencer.

Top module: `wfg_seq_top`

## Requirements
- R1: After reset, upd_strobe_o, fifo_rd_o, busy_o and cfg_err_o are 0 and rd_addr_o is 0.
- R2: Within one waveform, consecutive strobes are exactly U clock cycles apart, where U is the latched update interval when it is at least 40.
- R3: An update interval below 40, including 0, is treated as 40, so no two strobes are ever closer than 40 cycles.
- R4: With the iteration limit enabled, a run produces exactly upd_cnt_i × itr_cnt_i strobes and then returns to idle.
- R5: With the iteration limit disabled, waveforms repeat until a stop trigger; a stop sampled while busy clears busy_o on the next cycle, and no strobe follows.
- R6: With the trigger sampled at edge P, the first strobe appears U−1 cycles after P when the start delay is off. When the start delay is on with value D1, it appears D1+1+U−1 cycles after P.
- R7: The first strobe of a following waveform comes U cycles after the last strobe of the previous one. When the gap delay is on with value D2, it comes U+D2+1 cycles after.
- R8: busy_o is high from the cycle after the start trigger is accepted through the cycle of the final strobe, and low in the cycle after.
- R9: rd_addr_o shows the sample index written by each strobe. It advances by one after every strobe, wraps from pat_len_i−1 to 0, carries across waveforms, and is cleared to 0 by a successful arm.
- R10: Arming with upd_cnt_i = 0, with pat_len_i = 0, or with the iteration limit enabled and itr_cnt_i = 0 sets cfg_err_o, leaves the block unarmed, and makes the next start trigger produce no activity. A later valid arm clears cfg_err_o.
- R11: A start trigger has no effect unless the block is armed, and every run needs a fresh arm.
- R12: fifo_rd_o is high in exactly the cycles in which upd_strobe_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Software arm pulse; latches the configuration |
| start_trig_i | input | 1 | Start trigger |
| stop_trig_i | input | 1 | Stop trigger; aborts a run or disarms |
| ui_val_i | input | 24 | Update interval in timebase cycles |
| upd_cnt_i | input | 16 | Strobes per waveform |
| itr_cnt_i | input | 16 | Waveform repetitions |
| itr_en_i | input | 1 | 1 = repetition limit active, 0 = repeat until stop |
| pre_dly_en_i | input | 1 | Enable the start delay |
| pre_dly_i | input | 24 | Start delay value |
| gap_dly_en_i | input | 1 | Enable the delay between waveforms |
| gap_dly_i | input | 24 | Delay value between waveforms |
| pat_len_i | input | 14 | Stored pattern length in samples |
| upd_strobe_o | output | 1 | DAC write strobe |
| fifo_rd_o | output | 1 | Pattern read request |
| busy_o | output | 1 | Generation in progress |
| cfg_err_o | output | 1 | Configuration rejected at arm |
| rd_addr_o | output | 14 | Sample index written by the current strobe |

## Verification
The bench goes after the points where the counter chain hands over: the first strobe after a delayed or undelayed trigger, the seam between waveforms with and without a gap, and the final strobe. A design off by one at a hand-over shifts a strobe by a cycle. A design that misses the last update ends a run one strobe short or one strobe long. The clamp case uses an interval of 5, which a design without clamping would strobe eight times too fast. A short waveform over a longer pattern exposes a pointer that restarts at zero on each waveform. Zero counts at arm and a stop in endless mode catch designs that start anyway or keep strobing after a stop.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
  localparam int MIN_UI_DEF = 40;  // 1 MS/s ceiling at 40 MHz timebase

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_DLY1,
    ST_RUN,
    ST_DLY2
  } wfg_state_e;
endpackage

// File: rtl/wfg_cfg_chk.sv
module wfg_cfg_chk #(
  parameter int UI_W   = 24,
  parameter int UC_W   = 16,
  parameter int IC_W   = 16,
  parameter int ADDR_W = 14,
  parameter int MIN_UI = 40
) (
  input  logic [UI_W-1:0]   ui_i,
  input  logic [UC_W-1:0]   uc_i,
  input  logic [IC_W-1:0]   ic_i,
  input  logic              ic_en_i,
  input  logic [ADDR_W-1:0] plen_i,
  output logic              err_o,
  output logic [UI_W-1:0]   ui_eff_o
);
  localparam logic [UI_W-1:0] UI_FLOOR = UI_W'(MIN_UI);

  always_comb begin
    err_o    = (uc_i == '0) || (plen_i == '0) || (ic_en_i && (ic_i == '0));
    ui_eff_o = (ui_i < UI_FLOOR) ? UI_FLOOR : ui_i;
  end
endmodule

// File: rtl/wfg_intv_tmr.sv
module wfg_intv_tmr #(
  parameter int UI_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [UI_W-1:0] ui_i,
  output logic            tick_o
);
  logic [UI_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == ui_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wfg_addr_gen.sv
module wfg_addr_gen #(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] plen_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] plen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plen_q <= '0;
      addr_o <= '0;
    end else if (clr_i) begin
      plen_q <= plen_i;
      addr_o <= '0;
    end else if (step_i) begin
      addr_o <= (addr_o == plen_q - 1'b1) ? '0 : addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/wfg_ctrl.sv
module wfg_ctrl
  import wfg_pkg::*;
#(
  parameter int UI_W  = 24,
  parameter int UC_W  = 16,
  parameter int IC_W  = 16,
  parameter int DLY_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             err_i,
  input  logic [UI_W-1:0]  ui_eff_i,
  input  logic [UC_W-1:0]  uc_i,
  input  logic [IC_W-1:0]  ic_i,
  input  logic             ic_en_i,
  input  logic             d1_en_i,
  input  logic [DLY_W-1:0] d1_i,
  input  logic             d2_en_i,
  input  logic [DLY_W-1:0] d2_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             busy_o,
  output logic             cfg_err_o,
  output logic             arm_ok_o,
  output logic [UI_W-1:0]  ui_q_o
);
  wfg_state_e       state_q;
  logic [DLY_W-1:0] dly_cnt_q, d1_q, d2_q;
  logic [UC_W-1:0]  uc_q, upd_q;
  logic [IC_W-1:0]  ic_q, itr_q;
  logic             ic_en_q, d1_en_q, d2_en_q;
  logic             wave_end, run_end;

  assign run_o    = (state_q == ST_RUN);
  assign busy_o   = (state_q == ST_DLY1) || (state_q == ST_RUN) || (state_q == ST_DLY2);
  assign arm_ok_o = (state_q == ST_IDLE) && arm_i && !err_i;
  assign wave_end = tick_i && (upd_q == uc_q - 1'b1);
  assign run_end  = wave_end && ic_en_q && (itr_q == ic_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      dly_cnt_q <= '0;
      d1_q      <= '0;
      d2_q      <= '0;
      uc_q      <= '0;
      ic_q      <= '0;
      upd_q     <= '0;
      itr_q     <= '0;
      ic_en_q   <= 1'b0;
      d1_en_q   <= 1'b0;
      d2_en_q   <= 1'b0;
      ui_q_o    <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arm_i) begin
          cfg_err_o <= err_i;
          if (!err_i) begin
            state_q <= ST_ARMED;
            ui_q_o  <= ui_eff_i;
            uc_q    <= uc_i;
            ic_q    <= ic_i;
            ic_en_q <= ic_en_i;
            d1_en_q <= d1_en_i;
            d1_q    <= d1_i;
            d2_en_q <= d2_en_i;
            d2_q    <= d2_i;
          end
        end
        ST_ARMED: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (start_i) begin
            upd_q <= '0;
            itr_q <= '0;
            if (d1_en_q) begin
              state_q   <= ST_DLY1;
              dly_cnt_q <= d1_q;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_DLY1, ST_DLY2: begin
          if (stop_i)               state_q <= ST_IDLE;
          else if (dly_cnt_q == '0) state_q <= ST_RUN;
          else                      dly_cnt_q <= dly_cnt_q - 1'b1;
        end
        ST_RUN: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (run_end) begin
            state_q <= ST_IDLE;
          end else if (wave_end) begin
            upd_q <= '0;
            itr_q <= itr_q + 1'b1;
            if (d2_en_q) begin
              state_q   <= ST_DLY2;
              dly_cnt_q <= d2_q;
            end
          end else if (tick_i) begin
            upd_q <= upd_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wfg_seq_top.sv
module wfg_seq_top
  import wfg_pkg::*;
#(
  parameter int UI_W   = 24,
  parameter int UC_W   = 16,
  parameter int IC_W   = 16,
  parameter int DLY_W  = 24,
  parameter int ADDR_W = 14,
  parameter int MIN_UI = MIN_UI_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              start_trig_i,
  input  logic              stop_trig_i,
  input  logic [UI_W-1:0]   ui_val_i,
  input  logic [UC_W-1:0]   upd_cnt_i,
  input  logic [IC_W-1:0]   itr_cnt_i,
  input  logic              itr_en_i,
  input  logic              pre_dly_en_i,
  input  logic [DLY_W-1:0]  pre_dly_i,
  input  logic              gap_dly_en_i,
  input  logic [DLY_W-1:0]  gap_dly_i,
  input  logic [ADDR_W-1:0] pat_len_i,
  output logic              upd_strobe_o,
  output logic              fifo_rd_o,
  output logic              busy_o,
  output logic              cfg_err_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic            err, arm_ok, run, tick;
  logic [UI_W-1:0] ui_eff, ui_q;

  wfg_cfg_chk #(
    .UI_W(UI_W), .UC_W(UC_W), .IC_W(IC_W), .ADDR_W(ADDR_W), .MIN_UI(MIN_UI)
  ) u_cfg (
    .ui_i    (ui_val_i),
    .uc_i    (upd_cnt_i),
    .ic_i    (itr_cnt_i),
    .ic_en_i (itr_en_i),
    .plen_i  (pat_len_i),
    .err_o   (err),
    .ui_eff_o(ui_eff)
  );

  wfg_ctrl #(
    .UI_W(UI_W), .UC_W(UC_W), .IC_W(IC_W), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .start_i  (start_trig_i),
    .stop_i   (stop_trig_i),
    .err_i    (err),
    .ui_eff_i (ui_eff),
    .uc_i     (upd_cnt_i),
    .ic_i     (itr_cnt_i),
    .ic_en_i  (itr_en_i),
    .d1_en_i  (pre_dly_en_i),
    .d1_i     (pre_dly_i),
    .d2_en_i  (gap_dly_en_i),
    .d2_i     (gap_dly_i),
    .tick_i   (tick),
    .run_o    (run),
    .busy_o   (busy_o),
    .cfg_err_o(cfg_err_o),
    .arm_ok_o (arm_ok),
    .ui_q_o   (ui_q)
  );

  wfg_intv_tmr #(.UI_W(UI_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .ui_i  (ui_q),
    .tick_o(tick)
  );

  wfg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (arm_ok),
    .step_i(tick),
    .plen_i(pat_len_i),
    .addr_o(rd_addr_o)
  );

  assign upd_strobe_o = tick;
  assign fifo_rd_o    = tick;
endmodule

// File: rtl/wfg_seq_chk.sv
module wfg_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int MIN_UI = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              stop_trig_i,
  input logic              upd_strobe_o,
  input logic              busy_o,
  input logic              cfg_err_o,
  input logic [ADDR_W-1:0] rd_addr_o
);
  logic [31:0] gap_cnt;
  logic        have_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt   <= '0;
      have_prev <= 1'b0;
    end else if (upd_strobe_o) begin
      gap_cnt   <= '0;
      have_prev <= 1'b1;
    end else if (gap_cnt != '1) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_min_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_strobe_o && have_prev) |-> (gap_cnt >= 32'(MIN_UI - 1)));

  p_strobe_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_strobe_o |-> busy_o);

  p_err_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);

  p_stop_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_trig_i && busy_o) |=> !busy_o);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_strobe_o && !arm_i) |=> $stable(rd_addr_o));
endmodule

bind wfg_seq_top wfg_seq_chk #(.ADDR_W(ADDR_W), .MIN_UI(MIN_UI)) u_seq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .stop_trig_i (stop_trig_i),
  .upd_strobe_o(upd_strobe_o),
  .busy_o      (busy_o),
  .cfg_err_o   (cfg_err_o),
  .rd_addr_o   (rd_addr_o)
);

// File: tb/tb_wfg_seq_top.sv
module tb_wfg_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int MINUI      = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0, start = 1'b0, stop = 1'b0;
  logic [23:0] ui_val = '0;
  logic [15:0] uc_val = '0, ic_val = '0;
  logic        ic_en = 1'b0, d1_en = 1'b0, d2_en = 1'b0;
  logic [23:0] d1_val = '0, d2_val = '0;
  logic [13:0] plen = '0;
  logic        strobe, fifo_rd, busy, cfg_err;
  logic [13:0] rd_addr;

  int cyc = 0;
  int tests = 0, fails = 0, strobes = 0;
  int q_cyc[$];
  int q_addr[$];
  string q_tag[$];

  wfg_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .start_trig_i(start), .stop_trig_i(stop),
    .ui_val_i(ui_val), .upd_cnt_i(uc_val), .itr_cnt_i(ic_val), .itr_en_i(ic_en),
    .pre_dly_en_i(d1_en), .pre_dly_i(d1_val), .gap_dly_en_i(d2_en), .gap_dly_i(d2_val),
    .pat_len_i(plen), .upd_strobe_o(strobe), .fifo_rd_o(fifo_rd), .busy_o(busy),
    .cfg_err_o(cfg_err), .rd_addr_o(rd_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_rd !== strobe) chk(1'b0, "R12", "fifo_rd vs strobe", int'(fifo_rd), int'(strobe));
      if (strobe) begin
        strobes++;
        chk(fifo_rd === 1'b1, "R12", "fifo_rd on strobe", int'(fifo_rd), 1);
        if (q_cyc.size() == 0) begin
          chk(1'b0, "R4", "unexpected strobe at cycle", cyc, -1);
        end else begin
          int ec, ea;
          string et;
          ec = q_cyc.pop_front();
          ea = q_addr.pop_front();
          et = q_tag.pop_front();
          chk(cyc == ec, et, "strobe cycle", cyc, ec);
          chk(int'(rd_addr) == ea, "R9", "strobe sample index", int'(rd_addr), ea);
        end
      end
    end
  end

  task automatic do_arm(input int ui, input int uc, input int ic, input bit ie,
                        input bit e1, input int v1, input bit e2, input int v2, input int pl);
    ui_val = 24'(ui); uc_val = 16'(uc); ic_val = 16'(ic); ic_en = ie;
    d1_en = e1; d1_val = 24'(v1); d2_en = e2; d2_val = 24'(v2); plen = 14'(pl);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  // driver: arms, triggers, queues expected strobes; returns last expected cycle
  task automatic launch(input int ui, input int uc, input int n, input bit e1, input int v1,
                        input bit e2, input int v2, input int pl, output int last_t);
    int uie, t, a, trig;
    uie = (ui < MINUI) ? MINUI : ui;
    chk(cfg_err == 1'b0, "R10", "cfg_err after valid arm", int'(cfg_err), 0);
    chk(int'(rd_addr) == 0, "R9", "index cleared by arm", int'(rd_addr), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trig = cyc;
    chk(busy == 1'b1, "R8", "busy after trigger", int'(busy), 1);
    t = trig + (e1 ? v1 + 1 : 0) + uie - 1;
    a = 0;
    for (int k = 0; k < n; k++) begin
      q_cyc.push_back(t);
      q_addr.push_back(a);
      if (k == 0) q_tag.push_back("R6");
      else if (k % uc == 0) q_tag.push_back("R7");
      else q_tag.push_back(ui < MINUI ? "R3" : "R2");
      last_t = t;
      a = (a + 1) % pl;
      if ((k + 1) % uc == 0) t += uie + (e2 ? v2 + 1 : 0);
      else t += uie;
    end
  endtask

  task automatic run_case(input int ui, input int uc, input int ic, input bit e1, input int v1,
                          input bit e2, input int v2, input int pl);
    int last_t, s0;
    do_arm(ui, uc, ic, 1'b1, e1, v1, e2, v2, pl);
    launch(ui, uc, uc * ic, e1, v1, e2, v2, pl, last_t);
    while (cyc < last_t) @(negedge clk);
    chk(busy == 1'b1, "R8", "busy on final strobe", int'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after final strobe", int'(busy), 0);
    chk(q_cyc.size() == 0, "R4", "strobes still expected", q_cyc.size(), 0);
    // a new trigger without re-arm does nothing
    s0 = strobes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);
    chk(strobes == s0 && busy == 1'b0, "R11", "strobes after unarmed trigger", strobes - s0, 0);
  endtask

  task automatic err_case(input int uc, input int ic, input bit ie, input int pl);
    int s0;
    do_arm(50, uc, ic, ie, 1'b0, 0, 1'b0, 0, pl);
    chk(cfg_err == 1'b1, "R10", "cfg_err on bad config", int'(cfg_err), 1);
    s0 = strobes;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R10", "busy after rejected arm", int'(busy), 0);
    repeat (80) @(negedge clk);
    chk(strobes == s0, "R10", "strobes after rejected arm", strobes - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int last_t, s0;
    repeat (3) @(negedge clk);
    chk(strobe == 1'b0 && fifo_rd == 1'b0, "R1", "strobe in reset", int'(strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && cfg_err == 1'b0, "R1", "busy/err after reset", int'(busy) + int'(cfg_err), 0);
    chk(int'(rd_addr) == 0, "R1", "index after reset", int'(rd_addr), 0);

    run_case(50, 4, 2, 1'b0, 0, 1'b0, 0, 16);     // R2 R4
    run_case(5, 3, 1, 1'b0, 0, 1'b0, 0, 8);       // R3 clamp
    run_case(45, 3, 3, 1'b1, 20, 1'b1, 30, 5);    // R6 R7 R9 wrap
    run_case(40, 5, 2, 1'b1, 0, 1'b0, 0, 3);      // R7 seamless, R9 piecewise
    err_case(0, 2, 1'b1, 8);                      // R10 zero updates
    err_case(3, 0, 1'b1, 8);                      // R10 zero iterations
    err_case(3, 2, 1'b1, 0);                      // R10 zero pattern length

    // R5: endless repetition ended by stop
    do_arm(60, 3, 0, 1'b0, 1'b0, 0, 1'b1, 10, 4);
    launch(60, 3, 7, 1'b0, 0, 1'b1, 10, 4, last_t);
    while (cyc < last_t + 1) @(negedge clk);
    chk(busy == 1'b1, "R5", "busy before stop", int'(busy), 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0, "R5", "busy after stop", int'(busy), 0);
    s0 = strobes;
    repeat (150) @(negedge clk);
    chk(strobes == s0, "R5", "strobes after stop", strobes - s0, 0);
    chk(q_cyc.size() == 0, "R5", "strobes missing before stop", q_cyc.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule